// File: doc/BRIEF.md
# Pipelined Vertical-Crosswise Nibble Multiplier

This block multiplies two unsigned 4-bit operands and returns the 8-bit product through a three-register pipeline. It does not use array rows or Booth recoding. The product is built by the vertical-and-crosswise diagonal method. Every bit-pair product `a[i] & b[j]` is formed at once and grouped by its weight `i + j` into seven diagonal columns. Each column is summed on its own, and the bits of each column sum above the column's own weight are folded into the higher columns in a final carry ripple.

The first register stage captures all sixteen bit-pair products. The second captures the seven column sums, each with its carry bits. The third performs the carry addition and registers the product. A valid strobe rides beside the data. The pipeline takes a new operand pair on every clock edge and has no stall input, so a result of a sampled pair leaves the block a fixed number of edges later whatever the traffic pattern.

Top module: `vxm_mul_top`

## Requirements
- R1: When `valid_o` is high, `product_o` equals the unsigned product of the `a_i` and `b_i` values that were sampled together with the matching `valid_i`.
- R2: A `valid_i` sampled high at rising edge t gives `valid_o` high, with its product, after rising edge t+2. This is the third edge counted from the sampling edge, and the result stays until edge t+3.
- R3: Operand pairs presented on consecutive edges give results on consecutive edges in the same order. Throughput is one product per clock, with no gaps.
- R4: The second stage holds, for each column k from 0 to 6, the count of set terms `a[i] & b[j]` with i+j = k. That count never exceeds the column size: 1, 2, 3, 4, 3, 2, 1.
- R5: The full 8-bit range is produced. 15 x 15 gives 225, and any operand equal to 0 gives 0.
- R6: While `rst_ni` is low, `valid_o` and `product_o` are 0, and in-flight operands are discarded. After release, `valid_o` stays low until a newly sampled pair has passed through all three stages.
- R7: A `valid_i` sampled low produces `valid_o` low after edge t+2. Gaps in the input stream appear as gaps at the output in the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair present this cycle |
| a_i | input | 4 | Unsigned multiplicand |
| b_i | input | 4 | Unsigned multiplier |
| valid_o | output | 1 | Product present this cycle |
| product_o | output | 8 | Unsigned product a_i * b_i |

## Verification
The assertions check four properties on every clock. The first is that the output strobe is the input strobe delayed by exactly three edges. The second is that each valid product equals the product of the operands sampled three edges earlier. The third is that no column sum exceeds its term count. The fourth is that no product exceeds 225, and that the output stays idle for the first edges after reset.

Other behaviours only the bench scenarios can show. These are an exhaustive back-to-back sweep of all 256 operand pairs, with the results counted to prove there are no gaps, and the measured latency of an isolated pulse. They also include bubble patterns, and a reset that lands while results are in flight and must throw them away.

// File: rtl/vxm_pkg.sv
package vxm_pkg;

  // number of bit-pair terms on diagonal k of a w x w grid
  function automatic int col_terms(input int k, input int w);
    return (k < w) ? k + 1 : 2 * w - 1 - k;
  endfunction

  // bits needed to hold the largest column count (w terms)
  function automatic int sum_width(input int w);
    return $clog2(w + 1);
  endfunction

endpackage

// File: rtl/vxm_pp_stage.sv
module vxm_pp_stage #(
  parameter int W = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [W-1:0]          a_i,
  input  logic [W-1:0]          b_i,
  output logic                  valid_o,
  output logic [W-1:0][W-1:0]   pp_o
);

  logic [W-1:0][W-1:0] pp_d;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      for (int j = 0; j < W; j++) begin
        pp_d[i][j] = a_i[i] & b_i[j];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pp_o    <= '0;
    end else begin
      valid_o <= valid_i;
      pp_o    <= pp_d;
    end
  end

endmodule

// File: rtl/vxm_col_stage.sv
module vxm_col_stage #(
  parameter int W    = 4,
  parameter int NCOL = 2 * W - 1,
  parameter int CW   = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic [W-1:0][W-1:0]        pp_i,
  output logic                       valid_o,
  output logic [NCOL-1:0][CW-1:0]    col_o
);

  logic [NCOL-1:0][CW-1:0] col_d;

  // diagonal grouping: term (i,j) lands in column i+j
  always_comb begin
    col_d = '0;
    for (int i = 0; i < W; i++) begin
      for (int j = 0; j < W; j++) begin
        col_d[i+j] = col_d[i+j] + CW'(pp_i[i][j]);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      col_o   <= '0;
    end else begin
      valid_o <= valid_i;
      col_o   <= col_d;
    end
  end

  for (genvar k = 0; k < NCOL; k++) begin : g_col_chk
    localparam int TERMS = vxm_pkg::col_terms(k, W);
    AST_COL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(col_o[k]) <= TERMS) else $error("column %0d over range", k); // R4
  end

endmodule

// File: rtl/vxm_sum_stage.sv
module vxm_sum_stage #(
  parameter int W    = 4,
  parameter int NCOL = 2 * W - 1,
  parameter int CW   = 3,
  parameter int PW   = 2 * W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic [NCOL-1:0][CW-1:0]    col_i,
  output logic                       valid_o,
  output logic [PW-1:0]              product_o
);

  localparam int AW   = CW + 2;
  localparam int PMAX = ((1 << W) - 1) * ((1 << W) - 1);

  logic [PW-1:0][AW-1:0] cnt;
  logic [AW-1:0]         acc;
  logic [AW-1:0]         carry;
  logic [PW-1:0]         prod_d;

  // bit d of column c carries weight c+d; ripple the per-weight counts
  always_comb begin
    cnt = '0;
    for (int c = 0; c < NCOL; c++) begin
      for (int d = 0; d < CW; d++) begin
        if (c + d < PW) cnt[c+d] = cnt[c+d] + AW'(col_i[c][d]);
      end
    end
    carry = '0;
    acc   = '0;
    for (int k = 0; k < PW; k++) begin
      acc       = carry + cnt[k];
      prod_d[k] = acc[0];
      carry     = acc >> 1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      product_o <= '0;
    end else begin
      valid_o   <= valid_i;
      product_o <= prod_d;
    end
  end

  AST_PRODUCT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> int'(product_o) <= PMAX) else $error("product above max"); // R5

endmodule

// File: rtl/vxm_mul_top.sv
module vxm_mul_top #(
  parameter int W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  output logic              valid_o,
  output logic [2*W-1:0]    product_o
);

  localparam int PW   = 2 * W;
  localparam int NCOL = 2 * W - 1;
  localparam int CW   = vxm_pkg::sum_width(W);

  logic                    s1_valid;
  logic [W-1:0][W-1:0]     s1_pp;
  logic                    s2_valid;
  logic [NCOL-1:0][CW-1:0] s2_col;

  vxm_pp_stage #(.W(W)) u_pp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .valid_o (s1_valid),
    .pp_o    (s1_pp)
  );

  vxm_col_stage #(.W(W), .NCOL(NCOL), .CW(CW)) u_col (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_valid),
    .pp_i    (s1_pp),
    .valid_o (s2_valid),
    .col_o   (s2_col)
  );

  vxm_sum_stage #(.W(W), .NCOL(NCOL), .CW(CW), .PW(PW)) u_sum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (s2_valid),
    .col_i     (s2_col),
    .valid_o   (valid_o),
    .product_o (product_o)
  );

  // edges since reset release, saturating; gates the 3-deep history checks
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3) |-> (valid_o == $past(valid_i, 3))) else $error("latency"); // R2

  AST_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q == 2'd3) && !$past(valid_i, 3)) |-> !valid_o) else $error("bubble lost"); // R7

  AST_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((age_q == 2'd3) && valid_o) |->
      (product_o == PW'($past(a_i, 3)) * PW'($past(b_i, 3)))) else $error("product"); // R1

  AST_IDLE_AFTER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q != 2'd3) |-> !valid_o) else $error("early valid"); // R6

endmodule

// File: tb/vxm_mul_top_bench.sv
module vxm_mul_top_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk_i   = 1'b0;
  logic       rst_ni  = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] a_i     = '0;
  logic [3:0] b_i     = '0;
  logic       valid_o;
  logic [7:0] product_o;

  int checks = 0;
  int fails  = 0;
  int out_cnt = 0;
  bit track  = 1'b0;
  bit done   = 1'b0;

  typedef struct { bit v; int a; int b; } ent_t;
  ent_t hist[$];

  vxm_mul_top u_vxm_mul_top (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .valid_o   (valid_o),
    .product_o (product_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // reference: record every sampled input, clear on reset
  always @(posedge clk_i) begin
    if (!rst_ni) hist.delete();
    else begin
      ent_t e;
      e.v = valid_i; e.a = int'(a_i); e.b = int'(b_i);
      hist.push_back(e);
      if (hist.size() > 8) void'(hist.pop_front());
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk_i) begin
    if (track) begin
      if (!rst_ni) begin
        chk(valid_o == 1'b0, "R6 valid in reset", int'(valid_o), 0);
        chk(product_o == 8'd0, "R6 product in reset", int'(product_o), 0);
      end else begin
        bit exp_v;
        exp_v = (hist.size() >= 3) ? hist[hist.size()-3].v : 1'b0;
        chk(valid_o == exp_v, exp_v ? "R2 valid" : "R7 idle", int'(valid_o), int'(exp_v));
        if (valid_o) out_cnt++;
        if (exp_v && valid_o) begin
          int ea, eb;
          ea = hist[hist.size()-3].a;
          eb = hist[hist.size()-3].b;
          chk(int'(product_o) == ea * eb,
              (ea == 15 && eb == 15) || ea == 0 || eb == 0 ? "R5 range" : "R1 product",
              int'(product_o), ea * eb);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  task automatic drive(input bit v, input int a, input int b);
    valid_i = v;
    a_i = 4'(a);
    b_i = 4'(b);
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    int lat;
    track = 1'b1;
    repeat (3) step();
    rst_ni = 1'b1;
    step();

    // R3: exhaustive back-to-back sweep, one result per clock
    out_cnt = 0;
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        drive(1'b1, a, b);
    valid_i = 1'b0;
    repeat (3) step();
    chk(out_cnt == 256, "R3 sweep count", out_cnt, 256);

    // R7: bubble pattern
    for (int k = 0; k < 24; k++) drive((k % 3) != 1, (k * 7) % 16, (k * 5 + 3) % 16);
    drive(1'b0, 0, 0);
    repeat (4) step();

    // R2: isolated pulse latency measured in edges from the sampling edge
    valid_i = 1'b1; a_i = 4'd9; b_i = 4'd13;
    @(posedge clk_i);
    #2 valid_i = 1'b0;
    lat = 0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk_i);
      if (valid_o && lat == 0) lat = k;
    end
    chk(lat == 3, "R2 latency", lat, 3);

    // R5: range corners back-to-back
    drive(1'b1, 15, 15);
    drive(1'b1, 0, 15);
    drive(1'b1, 15, 0);
    drive(1'b1, 15, 1);
    drive(1'b0, 0, 0);
    repeat (4) step();

    // R6: reset with results in flight
    drive(1'b1, 7, 11);
    drive(1'b1, 12, 12);
    valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk(valid_o == 1'b0, "R6 async clear", int'(valid_o), 0);
    repeat (2) step();
    rst_ni = 1'b1;
    step();
    drive(1'b1, 14, 13);
    drive(1'b0, 0, 0);
    repeat (5) step();

    finish_run();
  end

endmodule